// File: doc/BRIEF.md
# Pipelined Q15 Fractional Multiplier

This block multiplies two signed 16-bit fractional operands. Each operand holds one sign bit and fifteen fraction bits, so it spans -1.0 up to just under +1.0. The full signed product has thirty fraction bits and is kept at 32 bits. It is then reduced back to the 16-bit fractional format in one of two ways. In round mode a one is added at the highest bit that will be dropped. In truncate mode nothing is added. In both modes an arithmetic right shift by fifteen positions follows.

The block is a two-stage pipeline. The first register stage holds the raw product. The second holds the reduced result. One operand pair can enter on every clock cycle. One input pair, -1.0 times -1.0, gives +1.0, which the 16-bit format cannot hold. That result is clamped to the largest positive value and flagged. A build parameter decides whether the raw 32-bit product is also brought out, aligned with the result.

Top module: `q15_round_mul`

## Requirements
- R1: While `rst_n` is low, and after reset until the first accepted operand pair has travelled through the pipeline, `out_vld` is 0 and `out_q`, `out_ovf` and `out_prod` are 0.
- R2: `out_vld` is high exactly two rising clock edges after a cycle in which `in_vld` was high. Operand pairs on back-to-back cycles are all accepted, and each gives its own result.
- R3: With `rnd_en` = 1, `out_q` equals bits 30 down to 15 of (A*B + 0x4000), where A*B is the signed 32-bit product. The result therefore rounds up exactly when bit 14 of the product is 1 and rounds down when that bit is 0.
- R4: With `rnd_en` = 0, `out_q` equals bits 30 down to 15 of A*B. This is a floor toward minus infinity for negative products.
- R5: For `op_a` = `op_b` = 0x8000, `out_q` is 0x7FFF and `out_ovf` is 1 in both modes. For every other pair, `out_ovf` is 0.
- R6: With the raw-product option enabled (the default), `out_prod` equals the signed 32-bit product A*B. It is presented in the same cycle as the matching `out_q`.
- R7: In a cycle with `out_vld` low, `out_q`, `out_ovf` and `out_prod` keep the values of the last valid result. Operands presented with `in_vld` low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_vld | input | 1 | Operand pair valid |
| op_a | input | 16 | Signed fractional operand A |
| op_b | input | 16 | Signed fractional operand B |
| rnd_en | input | 1 | 1 = round at the top dropped bit, 0 = truncate |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| out_q | output | 16 | Reduced signed fractional result |
| out_ovf | output | 1 | Result was clamped (the -1.0 times -1.0 case) |
| out_prod | output | 32 | Full signed product aligned with `out_q`, zero when the option is off |

## Verification
The operand sweep crosses every sign, the two extreme magnitudes and zero with a dense stride over the whole 16-bit range, in both modes. Each product therefore lands on bit-14 values of both 0 and 1. Round and truncate results differ only in those cases. Negative products with nonzero dropped bits separate an arithmetic shift from a logical shift and a floor from a round toward zero. The pair 0x8000 times 0x8000 sits apart from its neighbours 0x8000 times 0x8001 and 0x7FFF times 0x7FFF, which lie right at the clamp boundary without overflowing. Idle cycles with changing operands are mixed into the back-to-back stream, so a result that leaks through or comes out at the wrong latency shows up.

// File: rtl/q15_mul_pkg.sv
package q15_mul_pkg;

  typedef enum logic {
    REDUCE_TRUNC = 1'b0,
    REDUCE_ROUND = 1'b1
  } reduce_mode_e;

endpackage

// File: rtl/qmul_prod_stage.sv
module qmul_prod_stage
  import q15_mul_pkg::*;
#(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  reduce_mode_e  mode_i,
  output logic          vld_o,
  output logic [PW-1:0] prod_o,
  output reduce_mode_e  mode_o,
  output logic          clamp_o
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [PW-1:0] prod_d;
  logic          clamp_d;

  always_comb begin
    prod_d  = PW'($signed(a_i) * $signed(b_i));
    clamp_d = (a_i == MOST_NEG) && (b_i == MOST_NEG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_o  <= '0;
      mode_o  <= REDUCE_TRUNC;
      clamp_o <= 1'b0;
    end else if (vld_i) begin
      prod_o  <= prod_d;
      mode_o  <= mode_i;
      clamp_o <= clamp_d;
    end
  end

endmodule

// File: rtl/qmul_reduce_stage.sv
module qmul_reduce_stage
  import q15_mul_pkg::*;
#(
  parameter int W = 16,
  localparam int PW = 2 * W,
  localparam int FRAC = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [PW-1:0] prod_i,
  input  reduce_mode_e  mode_i,
  input  logic          clamp_i,
  output logic          vld_o,
  output logic [W-1:0]  q_o,
  output logic          ovf_o,
  output logic [PW-1:0] prod_o
);

  localparam logic [PW-1:0] HALF_LSB = PW'(1) << (FRAC - 1);
  localparam logic [W-1:0]  MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [PW-1:0] biased;
  logic [W-1:0]  q_d;

  always_comb begin
    biased = prod_i + ((mode_i == REDUCE_ROUND) ? HALF_LSB : '0);
    if (clamp_i) begin
      q_d = MOST_POS;
    end else begin
      q_d = W'($signed(biased) >>> FRAC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o    <= '0;
      ovf_o  <= 1'b0;
      prod_o <= '0;
    end else if (vld_i) begin
      q_o    <= q_d;
      ovf_o  <= clamp_i;
      prod_o <= prod_i;
    end
  end

endmodule

// File: rtl/q15_round_mul.sv
module q15_round_mul
  import q15_mul_pkg::*;
#(
  parameter int W = 16,
  parameter bit SHOW_PROD = 1'b1,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          rnd_en,
  output logic          out_vld,
  output logic [W-1:0]  out_q,
  output logic          out_ovf,
  output logic [PW-1:0] out_prod
);

  logic          s1_vld;
  logic [PW-1:0] s1_prod;
  reduce_mode_e  s1_mode;
  logic          s1_clamp;
  logic [PW-1:0] s2_prod;
  reduce_mode_e  in_mode;

  assign in_mode = rnd_en ? REDUCE_ROUND : REDUCE_TRUNC;

  qmul_prod_stage #(.W(W)) u_prod (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (in_vld),
    .a_i     (op_a),
    .b_i     (op_b),
    .mode_i  (in_mode),
    .vld_o   (s1_vld),
    .prod_o  (s1_prod),
    .mode_o  (s1_mode),
    .clamp_o (s1_clamp)
  );

  qmul_reduce_stage #(.W(W)) u_reduce (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (s1_vld),
    .prod_i  (s1_prod),
    .mode_i  (s1_mode),
    .clamp_i (s1_clamp),
    .vld_o   (out_vld),
    .q_o     (out_q),
    .ovf_o   (out_ovf),
    .prod_o  (s2_prod)
  );

  generate
    if (SHOW_PROD) begin : g_prod_out
      assign out_prod = s2_prod;
    end else begin : g_prod_off
      assign out_prod = s2_prod & '0;
    end
  endgenerate

endmodule

// File: rtl/qmul_chk.sv
module qmul_chk #(
  parameter int W = 16,
  parameter bit SHOW_PROD = 1'b1,
  localparam int PW = 2 * W,
  localparam int FRAC = W - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          rnd_en,
  input logic          out_vld,
  input logic [W-1:0]  out_q,
  input logic          out_ovf,
  input logic [PW-1:0] out_prod
);

  localparam logic [W-1:0]  MOST_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [PW-1:0] CLAMP_PROD = PW'(1) << (PW - 2);

  logic v1, v2, m1, m2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      m1 <= 1'b0;
      m2 <= 1'b0;
    end else begin
      v1 <= in_vld;
      v2 <= v1;
      if (in_vld) m1 <= rnd_en;
      if (v1) m2 <= m1;
    end
  end

  // R1 R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == v2);

  // R5
  clamp_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ovf) |-> (out_q == MOST_POS));

  // R7
  hold_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(out_q) && $stable(out_ovf) && $stable(out_prod)));

  generate
    if (SHOW_PROD) begin : g_prod_chk
      logic signed [PW-1:0] floor_q;
      logic [W-1:0]         ref_q;
      always_comb begin
        floor_q = $signed(out_prod) >>> FRAC;
        ref_q   = W'(floor_q) + {{(W-1){1'b0}}, m2 & out_prod[FRAC-1]};
      end

      // R3 R4
      reduce_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_ovf) |-> (out_q == ref_q));

      // R5 R6
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_prod != CLAMP_PROD) |-> !out_ovf);
    end
  endgenerate

endmodule

bind q15_round_mul qmul_chk #(.W(W), .SHOW_PROD(SHOW_PROD)) u_qmul_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .op_a     (op_a),
  .op_b     (op_b),
  .rnd_en   (rnd_en),
  .out_vld  (out_vld),
  .out_q    (out_q),
  .out_ovf  (out_ovf),
  .out_prod (out_prod)
);

// File: tb/sim_q15_round_mul.sv
module sim_q15_round_mul;

  localparam int PERIOD = 10;
  localparam int NOPS   = 72;

  typedef struct {
    bit          v;
    logic [15:0] q;
    bit          o;
    logic [31:0] p;
    bit          m;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic        rnd_en;
  logic        out_vld;
  logic [15:0] out_q;
  logic        out_ovf;
  logic [31:0] out_prod;

  int   total;
  int   bad;
  bit   finished;
  exp_t h1, h2;
  logic [15:0] last_q;
  logic [31:0] last_p;
  bit          last_o;

  q15_round_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .rnd_en(rnd_en), .out_vld(out_vld), .out_q(out_q), .out_ovf(out_ovf),
    .out_prod(out_prod)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] opval(int i);
    logic [15:0] edges [8];
    edges = '{16'h8000, 16'h8001, 16'hFFFF, 16'h0000,
              16'h0001, 16'h7FFF, 16'h4000, 16'hC000};
    if (i < 8) return edges[i];
    return 16'((i - 8) * 1031 - 32768 + 3);
  endfunction

  function automatic exp_t model(logic [15:0] a, logic [15:0] b, bit m);
    exp_t   e;
    longint p;
    longint s;
    p = longint'($signed(a)) * longint'($signed(b));
    e.v = 1'b1;
    e.m = m;
    e.p = 32'(p);
    if (a == 16'h8000 && b == 16'h8000) begin
      e.q = 16'h7FFF;
      e.o = 1'b1;
    end else begin
      s = (p + (m ? 64'sd16384 : 64'sd0)) >>> 15;
      e.q = 16'(s);
      e.o = 1'b0;
    end
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(bit v, logic [15:0] a, logic [15:0] b, bit m);
    exp_t nx;
    @(negedge clk);
    check(out_vld == h2.v, "R2 valid latency", 32'(out_vld), 32'(h2.v));
    if (h2.v && out_vld) begin
      if (h2.o) check(out_q == h2.q, "R5 clamp value", 32'(out_q), 32'(h2.q));
      else if (h2.m) check(out_q == h2.q, "R3 round", 32'(out_q), 32'(h2.q));
      else check(out_q == h2.q, "R4 truncate", 32'(out_q), 32'(h2.q));
      check(out_ovf == h2.o, "R5 overflow flag", 32'(out_ovf), 32'(h2.o));
      check(out_prod == h2.p, "R6 raw product", out_prod, h2.p);
      last_q = out_q;
      last_p = out_prod;
      last_o = out_ovf;
    end else if (!out_vld) begin
      check(out_q == last_q && out_prod == last_p && out_ovf == last_o,
            "R7 hold when idle", 32'(out_q), 32'(last_q));
    end
    nx = v ? model(a, b, m) : '{v: 1'b0, q: 16'h0, o: 1'b0, p: 32'h0, m: 1'b0};
    h2 = h1;
    h1 = nx;
    in_vld = v;
    op_a   = a;
    op_b   = b;
    rnd_en = m;
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 0;
    h1 = '{v: 1'b0, q: 16'h0, o: 1'b0, p: 32'h0, m: 1'b0};
    h2 = h1;
    last_q = 16'h0;
    last_p = 32'h0;
    last_o = 1'b0;
    rst_n = 1'b0;
    in_vld = 1'b0;
    op_a = 16'h8000;
    op_b = 16'h8000;
    rnd_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_vld == 1'b0, "R1 reset valid", 32'(out_vld), 0);
    check(out_q == 16'h0 && out_ovf == 1'b0 && out_prod == 32'h0,
          "R1 reset data", out_prod, 0);
    in_vld = 1'b1;
    @(negedge clk);
    check(out_vld == 1'b0, "R1 valid ignored in reset", 32'(out_vld), 0);
    in_vld = 1'b0;
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      int n = 0;
      for (int ia = 0; ia < NOPS; ia++) begin
        for (int ib = 0; ib < NOPS; ib++) begin
          n++;
          if (n % 7 == 0) step(1'b0, 16'(n * 37), 16'(n * 91), bit'(n & 1));
          step(1'b1, opval(ia), opval(ib), bit'(m));
        end
      end
    end
    repeat (4) step(1'b0, 16'h1234, 16'h8000, 1'b1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule